// File: doc/BRIEF.md
# TLB Access Rights and Fault Checker

This block decides what a single memory access may do once a matching translation entry has been found. It takes the rights fields of that entry, the privilege level and kind of the access, and a set of protection-ID registers. From these it produces the set of permitted operations (read, write, execute) and at most one fault code. It holds no translation storage. Accesses made with translation turned off are handled elsewhere.

Execute is granted only inside a privilege window bounded by the entry's two privilege fields. A matching protection ID takes away write permission. Faults are resolved in a fixed order. The dirty, break and reference-trap conditions also strip permission bits from the returned set, so that an access cached from that set still has to come back and re-check the entry. The result is registered: every output reflects the inputs sampled at the previous rising clock edge.

Top module: `tlb_rights_chk`

## Requirements
- R1: Base read permission (perm_q bit 0) is granted only when the request privilege is numerically at most the entry's high privilege bound `ent_pl_hi` and the rights type includes read.
- R2: Base write permission (perm_q bit 1) is granted only when the request privilege is at most the low bound `ent_pl_lo` and the rights type includes write.
- R3: Base execute permission (perm_q bit 2) is granted only when `ent_pl_lo` <= privilege <= `ent_pl_hi` and the rights type includes execute.
- R4: Rights type encoding: 0 gives read only, 1 gives read+write, 2 gives read+execute, 3 gives read+write+execute, and 4 to 7 give execute only.
- R5: When `req_idchk` is 1 and `ent_aid` is nonzero, a protection-ID register equal to {zero padding, ent_aid, 1'b1} removes write permission, and a write request (req_kind 2) then raises fault code 1. An access ID of zero, a disabled check, or a register with bit 0 clear has no effect.
- R6: A request of kind none (req_kind 0) never raises a fault. Its permission set is the base set after any R5 write removal, with no dirty, break or trap stripping.
- R7: If the requested operation (req_kind 1 read, 2 write, 3 execute) is not in the permission set, the fault is code 2 for execute and code 3 otherwise, and the permission set is returned without dirty, break or trap stripping.
- R8: For a permitted access with the dirty bit clear, write is removed from the set, and a write raises fault code 4.
- R9: For a permitted access with the break bit set, write is removed from the set, and a write raises fault code 5, taking precedence over code 4.
- R10: For a permitted access with the trap bit set, only execute is kept in the set, and any non-execute access raises fault code 6, taking precedence over codes 4 and 5.
- R11: Outputs are registered with one cycle of latency. Reset clears perm_q, fault_vld and fault_code to 0. fault_vld is 1 exactly when fault_code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_type | input | 3 | Entry rights type (R4) |
| ent_pl_hi | input | PL_W | Entry high privilege bound (read/execute) |
| ent_pl_lo | input | PL_W | Entry low privilege bound (write/execute) |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_brk | input | 1 | Entry data break bit |
| ent_trap | input | 1 | Entry reference trap bit |
| ent_aid | input | AID_W | Entry access ID; 0 means public |
| req_priv | input | PL_W | Request privilege level (0 is most privileged) |
| req_kind | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| req_idchk | input | 1 | Enables the protection-ID check |
| pid_regs | input | NUM_PID*PID_W | Protection-ID registers, register i at bits [i*PID_W +: PID_W] |
| perm_q | output | 3 | Permitted set: bit0 read, bit1 write, bit2 execute |
| fault_vld | output | 1 | A fault was raised |
| fault_code | output | 3 | Fault code, 0 when none |

## Verification
The bench targets the priority chain. A write to a page that is both clean and break-marked must report the break code. A trap-marked page must report the reference code even when the dirty or break condition also applies. A design with the order reversed reports the weaker fault. A refused access is checked for a permission set that has not been stripped: a design that strips before the permission test returns a smaller set, or a trap code instead of a rights fault. The protection-ID cases cover a zero ID, a disabled check, and a register with its low bit clear. A design that compares without the appended 1 bit would remove write permission on a miss. A design that skips the zero-ID test would remove write permission on a public page.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2,
        ACC_EX   = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_PID     = 3'd1,
        FLT_IPROT   = 3'd2,
        FLT_DRIGHTS = 3'd3,
        FLT_DIRTY   = 3'd4,
        FLT_BREAK   = 3'd5,
        FLT_PREF    = 3'd6
    } flt_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_N = 3;

    typedef struct packed {
        logic [PERM_N-1:0] perm;
        logic              vld;
        flt_e              code;
    } chk_res_t;

endpackage

// File: rtl/tlbr_perm_map.sv
module tlbr_perm_map #(
    parameter int PL_W = 2
) (
    input  logic [2:0]      ent_type,
    input  logic [PL_W-1:0] pl_hi,
    input  logic [PL_W-1:0] pl_lo,
    input  logic [PL_W-1:0] priv,
    output logic [2:0]      perm
);
    import tlbr_pkg::*;

    logic rd_ok, wr_ok, ex_ok;

    always_comb begin
        rd_ok = (priv <= pl_hi);
        wr_ok = (priv <= pl_lo);
        ex_ok = (pl_lo <= priv) && (priv <= pl_hi);
        perm  = '0;
        case (ent_type)
            3'd0: perm[PERM_R] = rd_ok;
            3'd1: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_W] = wr_ok;
            end
            3'd2: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_X] = ex_ok;
            end
            3'd3: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_W] = wr_ok;
                perm[PERM_X] = ex_ok;
            end
            default: perm[PERM_X] = ex_ok;
        endcase
    end

endmodule

// File: rtl/tlbr_pid_match.sv
module tlbr_pid_match #(
    parameter int AID_W   = 18,
    parameter int PID_W   = 32,
    parameter int NUM_PID = 4
) (
    input  logic [AID_W-1:0]         aid,
    input  logic                     chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     hit
);
    localparam int PAD_W = PID_W - AID_W - 1;

    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] eq_vec;

    assign key = {{PAD_W{1'b0}}, aid, 1'b1};

    for (genvar gi = 0; gi < NUM_PID; gi++) begin : g_cmp
        assign eq_vec[gi] = (pid_regs[gi*PID_W +: PID_W] == key);
    end

    assign hit = chk_en && (aid != '0) && (|eq_vec);

endmodule

// File: rtl/tlbr_fault_pri.sv
module tlbr_fault_pri (
    input  logic [2:0]         base_perm,
    input  logic               pid_hit,
    input  tlbr_pkg::acc_e     kind,
    input  logic               dirty,
    input  logic               brk,
    input  logic               trap,
    output tlbr_pkg::chk_res_t res
);
    import tlbr_pkg::*;

    logic [PERM_N-1:0] p;
    flt_e              code;
    logic              want;

    always_comb begin
        p    = base_perm;
        code = FLT_NONE;
        if (pid_hit) p[PERM_W] = 1'b0;

        case (kind)
            ACC_RD:  want = p[PERM_R];
            ACC_WR:  want = p[PERM_W];
            ACC_EX:  want = p[PERM_X];
            default: want = 1'b1;
        endcase

        if (pid_hit && kind == ACC_WR) begin
            code = FLT_PID;
        end else if (kind == ACC_NONE) begin
            code = FLT_NONE;
        end else if (!want) begin
            code = (kind == ACC_EX) ? FLT_IPROT : FLT_DRIGHTS;
        end else begin
            if (!dirty) begin
                p[PERM_W] = 1'b0;
                if (kind == ACC_WR) code = FLT_DIRTY;
            end
            if (brk) begin
                p[PERM_W] = 1'b0;
                if (kind == ACC_WR) code = FLT_BREAK;
            end
            if (trap) begin
                p[PERM_R] = 1'b0;
                p[PERM_W] = 1'b0;
                if (kind != ACC_EX) code = FLT_PREF;
            end
        end

        res.perm = p;
        res.code = code;
        res.vld  = (code != FLT_NONE);
    end

endmodule

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk #(
    parameter int PL_W    = 2,
    parameter int AID_W   = 18,
    parameter int PID_W   = 32,
    parameter int NUM_PID = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               ent_type,
    input  logic [PL_W-1:0]          ent_pl_hi,
    input  logic [PL_W-1:0]          ent_pl_lo,
    input  logic                     ent_dirty,
    input  logic                     ent_brk,
    input  logic                     ent_trap,
    input  logic [AID_W-1:0]         ent_aid,
    input  logic [PL_W-1:0]          req_priv,
    input  logic [1:0]               req_kind,
    input  logic                     req_idchk,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic [2:0]               perm_q,
    output logic                     fault_vld,
    output logic [2:0]               fault_code
);
    import tlbr_pkg::*;

    logic [2:0] base_perm;
    logic       pid_hit;
    chk_res_t   pri_res;
    chk_res_t   res_d, res_q;

    tlbr_perm_map #(.PL_W(PL_W)) u_map (
        .ent_type (ent_type),
        .pl_hi    (ent_pl_hi),
        .pl_lo    (ent_pl_lo),
        .priv     (req_priv),
        .perm     (base_perm)
    );

    tlbr_pid_match #(.AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NUM_PID)) u_pid (
        .aid      (ent_aid),
        .chk_en   (req_idchk),
        .pid_regs (pid_regs),
        .hit      (pid_hit)
    );

    tlbr_fault_pri u_pri (
        .base_perm (base_perm),
        .pid_hit   (pid_hit),
        .kind      (acc_e'(req_kind)),
        .dirty     (ent_dirty),
        .brk       (ent_brk),
        .trap      (ent_trap),
        .res       (pri_res)
    );

    always_comb begin
        res_d = pri_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{perm: '0, vld: 1'b0, code: FLT_NONE};
        end else begin
            res_q <= res_d;
        end
    end

    assign perm_q     = res_q.perm;
    assign fault_vld  = res_q.vld;
    assign fault_code = res_q.code;

endmodule

// File: rtl/tlb_rights_chk_sva.sv
module tlb_rights_chk_sva #(
    parameter int PL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      ent_type,
    input logic [PL_W-1:0] ent_pl_hi,
    input logic [PL_W-1:0] ent_pl_lo,
    input logic            ent_trap,
    input logic [PL_W-1:0] req_priv,
    input logic [1:0]      req_kind,
    input logic [2:0]      perm_q,
    input logic            fault_vld,
    input logic [2:0]      fault_code
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_read_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && perm_q[0]) |-> ($past(req_priv) <= $past(ent_pl_hi)));

    p_write_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && perm_q[1]) |-> ($past(req_priv) <= $past(ent_pl_lo)));

    p_exec_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && perm_q[2]) |->
        (($past(ent_pl_lo) <= $past(req_priv)) && ($past(req_priv) <= $past(ent_pl_hi))));

    p_exec_only_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ent_type) >= 3'd4) |-> (perm_q[1:0] == 2'b00));

    p_none_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_kind) == 2'd0) |-> !fault_vld);

    p_pref_needs_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && fault_code == 3'd6) |-> ($past(ent_trap) && perm_q[1:0] == 2'b00));

    p_flag_matches_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld == (fault_code != 3'd0));

    p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code <= 3'd6);

endmodule

bind tlb_rights_chk tlb_rights_chk_sva #(.PL_W(PL_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_type   (ent_type),
    .ent_pl_hi  (ent_pl_hi),
    .ent_pl_lo  (ent_pl_lo),
    .ent_trap   (ent_trap),
    .req_priv   (req_priv),
    .req_kind   (req_kind),
    .perm_q     (perm_q),
    .fault_vld  (fault_vld),
    .fault_code (fault_code)
);

// File: tb/tb_tlb_rights_chk.sv
`timescale 1ns/1ps
module tb_tlb_rights_chk;
    localparam int PL_W = 2, AID_W = 18, PID_W = 32, NUM_PID = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ent_type = '0;
    logic [PL_W-1:0] ent_pl_hi = '0, ent_pl_lo = '0;
    logic ent_dirty = 1'b1, ent_brk = 1'b0, ent_trap = 1'b0;
    logic [AID_W-1:0] ent_aid = '0;
    logic [PL_W-1:0] req_priv = '0;
    logic [1:0] req_kind = '0;
    logic req_idchk = 1'b0;
    logic [NUM_PID*PID_W-1:0] pid_regs = '0;
    logic [2:0] perm_q;
    logic fault_vld;
    logic [2:0] fault_code;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    tlb_rights_chk #(.PL_W(PL_W), .AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NUM_PID)) dut (
        .clk(clk), .rst_n(rst_n), .ent_type(ent_type), .ent_pl_hi(ent_pl_hi),
        .ent_pl_lo(ent_pl_lo), .ent_dirty(ent_dirty), .ent_brk(ent_brk),
        .ent_trap(ent_trap), .ent_aid(ent_aid), .req_priv(req_priv),
        .req_kind(req_kind), .req_idchk(req_idchk), .pid_regs(pid_regs),
        .perm_q(perm_q), .fault_vld(fault_vld), .fault_code(fault_code)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic set_ent(input logic [2:0] t, input int hi, input int lo,
                           input logic d, input logic b, input logic tr);
        ent_type = t; ent_pl_hi = PL_W'(hi); ent_pl_lo = PL_W'(lo);
        ent_dirty = d; ent_brk = b; ent_trap = tr;
    endtask

    // drive request at negedge, result registered at next posedge, sampled at following negedge
    task automatic req_chk(input int priv, input logic [1:0] kind,
                           input logic [2:0] exp_perm, input logic [2:0] exp_code,
                           input string tag);
        req_priv = PL_W'(priv); req_kind = kind;
        @(negedge clk);
        n_run++;
        if (perm_q !== exp_perm || fault_code !== exp_code ||
            fault_vld !== (exp_code != 3'd0)) begin
            n_fail++;
            $display("FAIL %s: perm=%b code=%0d vld=%b expected perm=%b code=%0d",
                     tag, perm_q, fault_code, fault_vld, exp_perm, exp_code);
        end
    endtask

    task automatic t_reset_r11();
        n_run++;
        if (perm_q !== 3'b000 || fault_vld !== 1'b0 || fault_code !== 3'd0) begin
            n_fail++;
            $display("FAIL R11 reset: perm=%b vld=%b code=%0d expected 000 0 0",
                     perm_q, fault_vld, fault_code);
        end
    endtask

    task automatic t_read_r1();
        set_ent(3'd0, 1, 0, 1, 0, 0);
        req_chk(1, 2'd1, 3'b001, 3'd0, "R1 read at bound");
        req_chk(2, 2'd1, 3'b000, 3'd3, "R1 read above bound");
    endtask

    task automatic t_write_r2();
        set_ent(3'd1, 3, 1, 1, 0, 0);
        req_chk(1, 2'd2, 3'b011, 3'd0, "R2 write at bound");
        req_chk(2, 2'd2, 3'b001, 3'd3, "R2 write above bound");
    endtask

    task automatic t_exec_r3();
        set_ent(3'd2, 2, 1, 1, 0, 0);
        req_chk(1, 2'd3, 3'b101, 3'd0, "R3 exec inside window");
        req_chk(0, 2'd3, 3'b001, 3'd2, "R3 exec below window");
        req_chk(3, 2'd3, 3'b000, 3'd2, "R3 exec above window");
    endtask

    task automatic t_map_r4();
        set_ent(3'd3, 3, 3, 1, 0, 0);
        req_chk(0, 2'd1, 3'b011, 3'd0, "R4 type3 read");
        set_ent(3'd5, 3, 0, 1, 0, 0);
        req_chk(2, 2'd3, 3'b100, 3'd0, "R4 type5 exec");
        req_chk(2, 2'd1, 3'b100, 3'd3, "R4 type5 read refused");
    endtask

    task automatic t_pid_r5();
        set_ent(3'd3, 3, 0, 1, 0, 0);
        ent_aid = AID_W'(5);
        pid_regs = '0;
        pid_regs[2*PID_W +: PID_W] = 32'h0000_000B;
        req_idchk = 1'b1;
        req_chk(0, 2'd2, 3'b101, 3'd1, "R5 write with id match");
        req_chk(0, 2'd1, 3'b101, 3'd0, "R5 read with id match");
        req_idchk = 1'b0;
        req_chk(0, 2'd2, 3'b111, 3'd0, "R5 check disabled");
        req_idchk = 1'b1;
        pid_regs[2*PID_W +: PID_W] = 32'h0000_000A;
        req_chk(0, 2'd2, 3'b111, 3'd0, "R5 low bit clear no match");
        ent_aid = '0;
        pid_regs[0 +: PID_W] = 32'h0000_0001;
        req_chk(0, 2'd2, 3'b111, 3'd0, "R5 public id zero");
        req_idchk = 1'b0;
        pid_regs = '0;
    endtask

    task automatic t_none_r6();
        set_ent(3'd3, 3, 0, 0, 1, 1);
        req_chk(0, 2'd0, 3'b111, 3'd0, "R6 none no strip");
        ent_aid = AID_W'(7);
        pid_regs[3*PID_W +: PID_W] = 32'h0000_000F;
        req_idchk = 1'b1;
        req_chk(0, 2'd0, 3'b101, 3'd0, "R6 none with id match");
        req_idchk = 1'b0; ent_aid = '0; pid_regs = '0;
    endtask

    task automatic t_refused_r7();
        set_ent(3'd1, 3, 1, 1, 0, 1);
        req_chk(2, 2'd2, 3'b001, 3'd3, "R7 refused write unstripped");
    endtask

    task automatic t_dirty_r8();
        set_ent(3'd1, 3, 3, 0, 0, 0);
        req_chk(0, 2'd2, 3'b001, 3'd4, "R8 dirty write");
        req_chk(0, 2'd1, 3'b001, 3'd0, "R8 dirty read");
    endtask

    task automatic t_break_r9();
        set_ent(3'd1, 3, 3, 0, 1, 0);
        req_chk(0, 2'd2, 3'b001, 3'd5, "R9 break over dirty");
        set_ent(3'd1, 3, 3, 1, 1, 0);
        req_chk(0, 2'd1, 3'b001, 3'd0, "R9 break read");
    endtask

    task automatic t_trap_r10();
        set_ent(3'd3, 3, 0, 0, 1, 1);
        req_chk(0, 2'd2, 3'b100, 3'd6, "R10 trap over break and dirty");
        req_chk(0, 2'd3, 3'b100, 3'd0, "R10 trap exec");
        req_chk(0, 2'd1, 3'b100, 3'd6, "R10 trap read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r11();
        rst_n = 1'b1;
        @(negedge clk);
        t_read_r1();
        t_write_r2();
        t_exec_r3();
        t_map_r4();
        t_pid_r5();
        t_none_r6();
        t_refused_r7();
        t_dirty_r8();
        t_break_r9();
        t_trap_r10();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule